// File: doc/BRIEF.md
# Three-Lane In-Order Issue Stage with Scoreboard

This block sits between a four-slot instruction queue and three single-entry lane buffers: a logical lane (AND, OR), an arithmetic lane (ADD, SUB) and a memory lane (load, store). In every cycle it looks at the valid queue slots, oldest first, and sends at most one instruction to each lane. A lane is served only while its input buffer is empty. The issue decision, the register file reads and the buffer write all happen in the same cycle. The buffer captures the instruction and its two operands on the closing clock edge, and the queue removes the slots flagged for removal on that same edge and compacts what remains.

Results are never forwarded, and a register cannot be read in the cycle in which it is written. For these reasons the block keeps one pending bit per architectural register. The bit is set when a producer issues. It is cleared on the edge that ends the cycle in which writeback reports that register. An instruction whose sources or destination are pending waits. A younger queue entry may go past an older blocked one only when the two share no register dependence and are not both memory operations.

Top module: `tri_lane_issue`

## Requirements
- R1: Each cycle at most one instruction goes to each lane, and it appears in output slot l of `iss_instr` with `iss_vld[l]` high. The lane is chosen from the 3-bit opcode. Codes 0 (AND) and 1 (OR) go to lane 0. Codes 2 (ADD) and 3 (SUB) go to lane 1. Any code with bit 2 set goes to lane 2; in that case bit 0 set means store and bit 0 clear means load.
- R2: `iss_vld[l]` is high only in a cycle in which `lane_empty[l]` is high.
- R3: An entry is IW=34 bits wide, laid out as op[33:31], rd[30:26], rs[25:21], rt[20:16] and imm[15:0]. Queue slot s occupies bits s*IW upward, and slot 0 is the oldest. `q_take[s]` is high in exactly the cycle in which slot s issues, and the number of bits set in `q_take` equals the number set in `iss_vld`.
- R4: Lane l drives the rs field of its issued entry on read port 2l and the rt field on port 2l+1. `iss_opa`/`iss_opb` slot l carries the data returned on those ports in the same cycle.
- R5: An entry does not issue while any register it reads has a pending bit. Every operation reads rs. All operations except loads also read rt.
- R6: An entry that writes rd does not issue while rd has a pending bit.
- R7: Issuing a writer sets its rd pending from the next cycle on. A writeback report for a register in cycle t clears the bit from cycle t+1, so a dependent entry can issue at t+1 at the earliest and never in cycle t.
- R8: An entry does not issue while any older valid entry writes a register it reads, writes the same rd, or reads the register it writes. This holds whether or not the older entry issues in that cycle.
- R9: Memory operations issue in queue order: a memory entry never issues while an older memory entry is still valid.
- R10: Among the eligible entries for a lane, the oldest is chosen. An entry that R5, R6, R8 and R9 leave free issues even when an older entry for any lane is blocked.
- R11: After reset no register is pending. With all queue slots invalid, nothing issues and nothing is taken.
- R12: A store never makes a register pending. The rt field of a load neither blocks it nor conflicts with other entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_valid | input | QD | Valid flag per queue slot, packed from slot 0 |
| q_entry | input | QD*IW | Queue slot contents |
| q_take | output | QD | Slots removed at the end of this cycle |
| lane_empty | input | 3 | Lane input buffer is empty |
| iss_vld | output | 3 | Lane buffer write strobe |
| iss_instr | output | 3*IW | Instruction written per lane |
| iss_opa | output | 3*XLEN | First operand per lane (rs) |
| iss_opb | output | 3*XLEN | Second operand per lane (rt) |
| rf_raddr | output | 6*RA | Register file read addresses |
| rf_rdata | input | 6*XLEN | Register file read data |
| wb_vld | input | 3 | Writeback report per lane |
| wb_reg | input | 3*RA | Register reported by writeback |

## Verification
The hardest case to reach is a dependent entry that becomes free exactly one cycle after its producer's writeback, while an unrelated younger entry for another lane passes it and the dependent's own lane buffer happens to be empty. The stimulus confines register numbers to a handful of values for the first part of the run, so that RAW, WAR and WAW pairs occur densely. Writeback latencies and buffer drain are both random, so pending bits clear at varied offsets from lane availability. A later phase opens up the full register range to exercise simultaneous issue on all three lanes.

// File: rtl/triad_pkg.sv
package triad_pkg;
    localparam int NLANE   = 3;
    localparam int LN_LOG  = 0;
    localparam int LN_ARI  = 1;
    localparam int LN_MEM  = 2;
    localparam int OP_W    = 3;

    // lane one-hot from opcode: bit2 -> memory, bit1 -> arithmetic, else logical
    function automatic logic [NLANE-1:0] lane_of(input logic [OP_W-1:0] op);
        logic [NLANE-1:0] oh;
        oh = '0;
        if (op[2])      oh[LN_MEM] = 1'b1;
        else if (op[1]) oh[LN_ARI] = 1'b1;
        else            oh[LN_LOG] = 1'b1;
        return oh;
    endfunction

    function automatic logic is_store(input logic [OP_W-1:0] op);
        return op[2] & op[0];
    endfunction

    function automatic logic is_load(input logic [OP_W-1:0] op);
        return op[2] & ~op[0];
    endfunction
endpackage

// File: rtl/triad_decode.sv
module triad_decode
    import triad_pkg::*;
#(
    parameter int RA = 5,
    localparam int HW = OP_W + 3 * RA
) (
    input  logic [HW-1:0]    hdr,
    output logic [NLANE-1:0] lane_oh,
    output logic [RA-1:0]    rd,
    output logic [RA-1:0]    rs,
    output logic [RA-1:0]    rt,
    output logic             wr,
    output logic             rd_rt,
    output logic             mem
);
    logic [OP_W-1:0] op;

    always_comb begin
        op      = hdr[HW-1 -: OP_W];
        rd      = hdr[3*RA-1 -: RA];
        rs      = hdr[2*RA-1 -: RA];
        rt      = hdr[RA-1:0];
        lane_oh = lane_of(op);
        wr      = ~is_store(op);
        rd_rt   = ~is_load(op);
        mem     = op[2];
    end
endmodule

// File: rtl/triad_select.sv
module triad_select
    import triad_pkg::*;
#(
    parameter int QD   = 4,
    parameter int NREG = 32,
    localparam int RA  = $clog2(NREG),
    localparam int SW  = (QD > 1) ? $clog2(QD) : 1
) (
    input  logic [QD-1:0]    q_valid,
    input  logic [NLANE-1:0] lane_oh [QD],
    input  logic [RA-1:0]    rd      [QD],
    input  logic [RA-1:0]    rs      [QD],
    input  logic [RA-1:0]    rt      [QD],
    input  logic             wr      [QD],
    input  logic             rd_rt   [QD],
    input  logic             mem     [QD],
    input  logic [NREG-1:0]  busy,
    input  logic [NLANE-1:0] lane_empty,
    output logic [QD-1:0]    take,
    output logic [NLANE-1:0] lane_vld,
    output logic [SW-1:0]    lane_slot [NLANE]
);
    always_comb begin
        logic             rdy;
        logic [NLANE-1:0] claimed;
        claimed = '0;
        take    = '0;
        for (int l = 0; l < NLANE; l++) lane_slot[l] = '0;
        for (int i = 0; i < QD; i++) begin
            // scoreboard hazards against in-flight producers
            rdy = q_valid[i] & ~busy[rs[i]] & ~(rd_rt[i] & busy[rt[i]])
                & ~(wr[i] & busy[rd[i]]);
            // ordering hazards against every older queued entry
            for (int j = 0; j < QD; j++) begin
                if (j < i && q_valid[j]) begin
                    if (wr[j] && (rd[j] == rs[i] || (rd_rt[i] && rd[j] == rt[i]))) rdy = 1'b0;
                    if (wr[j] && wr[i] && rd[j] == rd[i])                          rdy = 1'b0;
                    if (wr[i] && (rs[j] == rd[i] || (rd_rt[j] && rt[j] == rd[i]))) rdy = 1'b0;
                    if (mem[i] && mem[j])                                          rdy = 1'b0;
                end
            end
            if (rdy && ((lane_oh[i] & lane_empty & ~claimed) != '0)) begin
                take[i] = 1'b1;
                claimed = claimed | lane_oh[i];
                for (int l = 0; l < NLANE; l++)
                    if (lane_oh[i][l]) lane_slot[l] = SW'(i);
            end
        end
        lane_vld = claimed;
    end
endmodule

// File: rtl/triad_scoreboard.sv
module triad_scoreboard
    import triad_pkg::*;
#(
    parameter int NREG = 32,
    localparam int RA  = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NLANE-1:0]    set_vld,
    input  logic [NLANE*RA-1:0] set_reg,
    input  logic [NLANE-1:0]    clr_vld,
    input  logic [NLANE*RA-1:0] clr_reg,
    output logic [NREG-1:0]     busy
);
    typedef struct packed {
        logic [NREG-1:0] pend;
    } sb_t;

    sb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int l = 0; l < NLANE; l++)
            if (clr_vld[l]) st_d.pend[clr_reg[l*RA +: RA]] = 1'b0;
        for (int l = 0; l < NLANE; l++)
            if (set_vld[l]) st_d.pend[set_reg[l*RA +: RA]] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.pend;
endmodule

// File: rtl/tri_lane_issue.sv
module tri_lane_issue
    import triad_pkg::*;
#(
    parameter int QD    = 4,
    parameter int NREG  = 32,
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    localparam int RA   = $clog2(NREG),
    localparam int IW   = OP_W + 3 * RA + IMM_W,
    localparam int SW   = (QD > 1) ? $clog2(QD) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [QD-1:0]             q_valid,
    input  logic [QD*IW-1:0]          q_entry,
    output logic [QD-1:0]             q_take,
    input  logic [NLANE-1:0]          lane_empty,
    output logic [NLANE-1:0]          iss_vld,
    output logic [NLANE*IW-1:0]       iss_instr,
    output logic [NLANE*XLEN-1:0]     iss_opa,
    output logic [NLANE*XLEN-1:0]     iss_opb,
    output logic [2*NLANE*RA-1:0]     rf_raddr,
    input  logic [2*NLANE*XLEN-1:0]   rf_rdata,
    input  logic [NLANE-1:0]          wb_vld,
    input  logic [NLANE*RA-1:0]       wb_reg
);
    logic [IW-1:0]    ent     [QD];
    logic [NLANE-1:0] f_lane  [QD];
    logic [RA-1:0]    f_rd    [QD];
    logic [RA-1:0]    f_rs    [QD];
    logic [RA-1:0]    f_rt    [QD];
    logic             f_wr    [QD];
    logic             f_rdrt  [QD];
    logic             f_mem   [QD];

    for (genvar s = 0; s < QD; s++) begin : g_slot
        assign ent[s] = q_entry[s*IW +: IW];
        triad_decode #(.RA(RA)) u_dec (
            .hdr     (ent[s][IW-1:IMM_W]),
            .lane_oh (f_lane[s]),
            .rd      (f_rd[s]),
            .rs      (f_rs[s]),
            .rt      (f_rt[s]),
            .wr      (f_wr[s]),
            .rd_rt   (f_rdrt[s]),
            .mem     (f_mem[s])
        );
    end

    logic [NREG-1:0]     busy;
    logic [NLANE-1:0]    lane_vld;
    logic [SW-1:0]       lane_slot [NLANE];
    logic [NLANE-1:0]    set_vld;
    logic [NLANE*RA-1:0] set_reg;

    triad_select #(.QD(QD), .NREG(NREG)) u_sel (
        .q_valid    (q_valid),
        .lane_oh    (f_lane),
        .rd         (f_rd),
        .rs         (f_rs),
        .rt         (f_rt),
        .wr         (f_wr),
        .rd_rt      (f_rdrt),
        .mem        (f_mem),
        .busy       (busy),
        .lane_empty (lane_empty),
        .take       (q_take),
        .lane_vld   (lane_vld),
        .lane_slot  (lane_slot)
    );

    triad_scoreboard #(.NREG(NREG)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vld (set_vld),
        .set_reg (set_reg),
        .clr_vld (wb_vld),
        .clr_reg (wb_reg),
        .busy    (busy)
    );

    // per-lane routing of the chosen slot to buffer, read ports and scoreboard
    always_comb begin
        for (int l = 0; l < NLANE; l++) begin
            iss_instr[l*IW +: IW]         = ent[lane_slot[l]];
            rf_raddr[(2*l)*RA +: RA]      = f_rs[lane_slot[l]];
            rf_raddr[(2*l+1)*RA +: RA]    = f_rt[lane_slot[l]];
            iss_opa[l*XLEN +: XLEN]       = rf_rdata[(2*l)*XLEN +: XLEN];
            iss_opb[l*XLEN +: XLEN]       = rf_rdata[(2*l+1)*XLEN +: XLEN];
            set_vld[l]                    = lane_vld[l] & f_wr[lane_slot[l]];
            set_reg[l*RA +: RA]           = f_rd[lane_slot[l]];
        end
        iss_vld = lane_vld;
    end
endmodule

// File: rtl/tri_lane_issue_chk.sv
module tri_lane_issue_chk
    import triad_pkg::*;
#(
    parameter int QD   = 4,
    parameter int NREG = 32,
    localparam int RA  = $clog2(NREG),
    localparam int HW  = OP_W + 3 * RA
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [QD-1:0]        q_valid,
    input logic [QD-1:0]        q_take,
    input logic [NLANE-1:0]     lane_empty,
    input logic [NLANE-1:0]     iss_vld,
    input logic [NLANE*HW-1:0]  iss_hdr,
    input logic [NLANE-1:0]     wb_vld,
    input logic [NLANE*RA-1:0]  wb_reg
);
    logic [NREG-1:0] rmask, wmask, wbmask, wmask_q;

    always_comb begin
        logic [OP_W-1:0] op;
        rmask  = '0;
        wmask  = '0;
        wbmask = '0;
        for (int l = 0; l < NLANE; l++) begin
            op = iss_hdr[l*HW + HW - 1 -: OP_W];
            if (iss_vld[l]) begin
                rmask[iss_hdr[l*HW + 2*RA - 1 -: RA]] = 1'b1;
                if (!is_load(op))  rmask[iss_hdr[l*HW + RA - 1 -: RA]] = 1'b1;
                if (!is_store(op)) wmask[iss_hdr[l*HW + 3*RA - 1 -: RA]] = 1'b1;
            end
            if (wb_vld[l]) wbmask[wb_reg[l*RA +: RA]] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wmask_q <= '0;
        else        wmask_q <= wmask;
    end

    p_lane_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld & ~lane_empty) == '0);

    p_take_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(q_take) == $countones(iss_vld)) && ((q_take & ~q_valid) == '0));

    // R5: a producer issued last cycle cannot feed a reader this cycle
    p_no_early_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wmask_q & rmask) == '0);

    // R7: a register reported by writeback is not read in that same cycle
    p_wb_same_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wbmask & rmask) == '0);

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        p_lane_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
            iss_vld[l] |-> (lane_of(iss_hdr[l*HW + HW - 1 -: OP_W]) == NLANE'(1 << l)));
    end
endmodule

bind tri_lane_issue tri_lane_issue_chk #(.QD(QD), .NREG(NREG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .q_valid    (q_valid),
    .q_take     (q_take),
    .lane_empty (lane_empty),
    .iss_vld    (iss_vld),
    .iss_hdr    ({iss_instr[2*IW+IMM_W +: IW-IMM_W],
                  iss_instr[IW+IMM_W +: IW-IMM_W],
                  iss_instr[IMM_W +: IW-IMM_W]}),
    .wb_vld     (wb_vld),
    .wb_reg     (wb_reg)
);

// File: tb/tri_lane_issue_bench.sv
module tri_lane_issue_bench;
    localparam int CLK_PERIOD = 10;
    localparam int QD = 4, NREG = 32, XLEN = 32, IMM_W = 16;
    localparam int RA = 5, IW = 34, NL = 3, NCYC = 4000, FMAX = 64;

    logic clk = 1'b0;
    logic rst_n;
    logic [QD-1:0]         q_valid;
    logic [QD*IW-1:0]      q_entry;
    logic [QD-1:0]         q_take;
    logic [NL-1:0]         lane_empty;
    logic [NL-1:0]         iss_vld;
    logic [NL*IW-1:0]      iss_instr;
    logic [NL*XLEN-1:0]    iss_opa, iss_opb;
    logic [2*NL*RA-1:0]    rf_raddr;
    logic [2*NL*XLEN-1:0]  rf_rdata;
    logic [NL-1:0]         wb_vld;
    logic [NL*RA-1:0]      wb_reg;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_lane_issue #(.QD(QD), .NREG(NREG), .XLEN(XLEN), .IMM_W(IMM_W)) u_tri_lane_issue (
        .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_entry(q_entry), .q_take(q_take),
        .lane_empty(lane_empty), .iss_vld(iss_vld), .iss_instr(iss_instr),
        .iss_opa(iss_opa), .iss_opb(iss_opb), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .wb_vld(wb_vld), .wb_reg(wb_reg)
    );

    // behavioural model state
    logic [XLEN-1:0] rf_m [NREG];
    bit              pend_m [NREG];
    logic [IW-1:0]   qm [QD];
    int              qn;
    bit              full_m [NL];
    int              fl_reg [FMAX], fl_lane [FMAX], fl_cnt [FMAX];
    int              fn;
    bit              exp_vld [NL];
    int              exp_slot [NL];
    bit              exp_take [QD];
    int              n_chk = 0, n_fail = 0;
    int              reg_span;
    bit              done = 0;

    always_comb
        for (int p = 0; p < 2*NL; p++)
            rf_rdata[p*XLEN +: XLEN] = rf_m[rf_raddr[p*RA +: RA]];

    function automatic int f_op(logic [IW-1:0] e); return int'(e[33:31]); endfunction
    function automatic int f_rd(logic [IW-1:0] e); return int'(e[30:26]); endfunction
    function automatic int f_rs(logic [IW-1:0] e); return int'(e[25:21]); endfunction
    function automatic int f_rt(logic [IW-1:0] e); return int'(e[20:16]); endfunction
    function automatic int lane_k(int op); return (op >= 4) ? 2 : (op >= 2) ? 1 : 0; endfunction
    function automatic bit writes(int op); return !(op == 5 || op == 7); endfunction
    function automatic bit reads_rt(int op); return !(op == 4 || op == 6); endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic drive_inputs;
        q_valid = '0;
        q_entry = '0;
        for (int s = 0; s < qn; s++) begin
            q_valid[s] = 1'b1;
            q_entry[s*IW +: IW] = qm[s];
        end
        for (int l = 0; l < NL; l++) lane_empty[l] = !full_m[l];
    endtask

    // expected issue decisions from the requirements (R5, R6, R8, R9, R10, R12)
    task automatic predict;
        bit claimed [NL];
        for (int l = 0; l < NL; l++) begin claimed[l] = 0; exp_vld[l] = 0; exp_slot[l] = 0; end
        for (int i = 0; i < QD; i++) exp_take[i] = 0;
        for (int i = 0; i < qn; i++) begin
            int op = f_op(qm[i]), rd = f_rd(qm[i]), rs = f_rs(qm[i]), rt = f_rt(qm[i]);
            int ln = lane_k(op);
            bit ok = !pend_m[rs] && !(reads_rt(op) && pend_m[rt]) && !(writes(op) && pend_m[rd]);
            for (int j = 0; j < i; j++) begin
                int oj = f_op(qm[j]);
                if (writes(oj) && (f_rd(qm[j]) == rs || (reads_rt(op) && f_rd(qm[j]) == rt))) ok = 0;
                if (writes(oj) && writes(op) && f_rd(qm[j]) == rd) ok = 0;
                if (writes(op) && (f_rs(qm[j]) == rd || (reads_rt(oj) && f_rt(qm[j]) == rd))) ok = 0;
                if (ln == 2 && lane_k(oj) == 2) ok = 0;
            end
            if (ok && !full_m[ln] && !claimed[ln]) begin
                claimed[ln] = 1; exp_vld[ln] = 1; exp_slot[ln] = i; exp_take[i] = 1;
            end
        end
    endtask

    task automatic compare;
        for (int l = 0; l < NL; l++) begin
            check(iss_vld[l] == exp_vld[l], "R2 R5 R6 R7 R8 R9 R10 R12 lane strobe", 64'(iss_vld[l]), 64'(exp_vld[l]));
            if (exp_vld[l] && iss_vld[l]) begin
                logic [IW-1:0] e = qm[exp_slot[l]];
                check(iss_instr[l*IW +: IW] == e, "R1 lane instruction", 64'(iss_instr[l*IW +: IW]), 64'(e));
                check(iss_opa[l*XLEN +: XLEN] == rf_m[f_rs(e)], "R4 operand a", 64'(iss_opa[l*XLEN +: XLEN]), 64'(rf_m[f_rs(e)]));
                check(iss_opb[l*XLEN +: XLEN] == rf_m[f_rt(e)], "R4 operand b", 64'(iss_opb[l*XLEN +: XLEN]), 64'(rf_m[f_rt(e)]));
            end
        end
        for (int s = 0; s < QD; s++)
            check(q_take[s] == exp_take[s], "R3 slot removal", 64'(q_take[s]), 64'(exp_take[s]));
    endtask

    function automatic logic [IW-1:0] gen_entry(int span);
        logic [IW-1:0] e;
        e[33:31] = 3'($urandom_range(0, 7));
        e[30:26] = 5'($urandom_range(0, span - 1));
        e[25:21] = 5'($urandom_range(0, span - 1));
        e[20:16] = 5'($urandom_range(0, span - 1));
        e[15:0]  = 16'($urandom);
        return e;
    endfunction

    // state update at a clock edge using the decisions of the closing cycle
    task automatic advance;
        int nq;
        logic [IW-1:0] tmp [QD];
        for (int l = 0; l < NL; l++)
            if (wb_vld[l]) begin
                pend_m[wb_reg[l*RA +: RA]] = 0;
                rf_m[wb_reg[l*RA +: RA]] = $urandom;
            end
        for (int l = 0; l < NL; l++)
            if (full_m[l] && $urandom_range(0, 2) != 0) full_m[l] = 0;
        for (int l = 0; l < NL; l++)
            if (exp_vld[l]) begin
                logic [IW-1:0] e = qm[exp_slot[l]];
                full_m[l] = 1;
                if (writes(f_op(e))) begin
                    pend_m[f_rd(e)] = 1;
                    fl_reg[fn] = f_rd(e); fl_lane[fn] = l; fl_cnt[fn] = $urandom_range(1, 4);
                    fn++;
                end
            end
        nq = 0;
        for (int s = 0; s < qn; s++) if (!exp_take[s]) begin tmp[nq] = qm[s]; nq++; end
        for (int s = 0; s < nq; s++) qm[s] = tmp[s];
        qn = nq;
        wb_vld = '0;
        wb_reg = '0;
        for (int k = 0; k < fn; k++) fl_cnt[k]--;
        for (int l = 0; l < NL; l++) begin
            int hit = -1;
            for (int k = 0; k < fn; k++)
                if (hit < 0 && fl_lane[k] == l && fl_cnt[k] <= 0) hit = k;
            if (hit >= 0) begin
                wb_vld[l] = 1'b1;
                wb_reg[l*RA +: RA] = 5'(fl_reg[hit]);
                for (int k = hit; k < fn - 1; k++) begin
                    fl_reg[k] = fl_reg[k+1]; fl_lane[k] = fl_lane[k+1]; fl_cnt[k] = fl_cnt[k+1];
                end
                fn--;
            end
        end
        while (qn < QD && $urandom_range(0, 3) != 0) begin
            qm[qn] = gen_entry(reg_span);
            qn++;
        end
        drive_inputs();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        report();
    end

    initial begin
        rst_n = 1'b0;
        qn = 0; fn = 0; reg_span = 4;
        wb_vld = '0; wb_reg = '0;
        for (int r = 0; r < NREG; r++) begin rf_m[r] = 32'(r * 17 + 3); pend_m[r] = 0; end
        for (int l = 0; l < NL; l++) begin full_m[l] = 0; exp_vld[l] = 0; end
        for (int s = 0; s < QD; s++) exp_take[s] = 0;
        drive_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(iss_vld == '0, "R11 no issue in reset", 64'(iss_vld), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(iss_vld == '0 && q_take == '0, "R11 idle with empty queue", 64'({iss_vld, q_take}), 64'd0);
        // R11: every register free right after reset, so all three lanes fill at once
        qm[0] = {3'd0, 5'd1, 5'd2, 5'd3, 16'h0};
        qm[1] = {3'd2, 5'd4, 5'd5, 5'd6, 16'h0};
        qm[2] = {3'd4, 5'd7, 5'd8, 5'd9, 16'h0};
        qn = 3;
        drive_inputs();
        #1;
        predict();
        check(iss_vld == 3'b111, "R11 clean scoreboard after reset", 64'(iss_vld), 64'h7);
        compare();
        for (int c = 0; c < NCYC; c++) begin
            if (c == NCYC / 2) reg_span = 32;
            @(posedge clk);
            #1;
            advance();
            @(negedge clk);
            predict();
            compare();
        end
        report();
    end
endmodule